// File: doc/BRIEF.md
# Interleaved Three-Phase PWM Generator

This block drives the gates of three paralleled boost stages from a single duty command. A free-running period counter sets the switching period (1000 clock cycles by default, which is 10 us at 100 MHz). All three phases use the same on-time. Each phase's leading edge sits one third of a period after the previous phase, so the stages run 120 degrees apart. A phase whose on-window runs past the end of the counter wraps into the start of the next period. This means the windows of different phases may overlap when the duty is large.

The duty word gives the on-time in clock counts. A control loop that samples once per switching period presents a new duty word together with a one-cycle valid strobe. The block holds that value and applies it only at the start of the next period, so no phase ever sees a change in the middle of its window. A one-cycle period-start pulse marks counter zero, so the sampling logic can lock to it. Clearing the enable, or applying the synchronous reset, forces every gate low and returns the counter to zero.

Top module: `ilpwm_interleave`

## Requirements
- R1: While enabled, the internal counter steps from 0 to 999 and then back to 0, so successive period-start pulses are exactly 1000 cycles apart.
- R2: `period_start_o` is high in exactly those cycles where the block is enabled, out of reset and the counter is 0. It is never high for two cycles in a row.
- R3: Phase k (k = 0, 1, 2 as bit k of `gate_o`) has start offset 0, 333 or 667 counts. It is high exactly when enabled and ((count − offset) mod 1000) is below the applied duty.
- R4: An applied duty of 0 keeps all three gates low for the whole period.
- R5: A duty word of 1000 or more is saturated to 1000, and all three gates are then high for the whole period.
- R6: A duty captured in the middle of a period takes effect at the next count 0. The current period completes with the old value.
- R7: While `duty_vld_i` is low, changes on `duty_i` have no effect on the gates.
- R8: Reset or a low `en_i` forces all gates and `period_start_o` low in that same cycle and clears the counter. On the first enabled cycle afterwards, the counter is 0 and `period_start_o` is high. A duty strobed while disabled applies from that first cycle.
- R9: Over each complete enabled period, every phase is high for min(duty, 1000) cycles.
- R10: A phase whose window passes the end of the counter wraps. With a duty above 333, phase 2 is high at count 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| en_i | input | 1 | Run enable; low forces gates low and clears the counter |
| duty_i | input | 10 | On-time in clock counts |
| duty_vld_i | input | 1 | Strobe that captures `duty_i` |
| gate_o | output | 3 | Gate drive, bit k is phase k |
| period_start_o | output | 1 | One-cycle pulse at count 0 |

## Verification
The assertions take for granted that reset is applied before the first enabled cycle. They also assume that `duty_i` may hold any 10-bit value, including values above the period, and that `en_i` may drop at any point in a period. The stimulus keeps within this: it holds reset for several cycles, then draws duty words from the full 10-bit range and places the valid strobe at random counts, including at count 999. It also drops the enable in the middle of a period. Directed cases cover duties of 0, 1, the offset edges 332 to 334, 999, 1000 and 1023, a strobe in the middle of a period, and duty changes with no strobe.

// File: rtl/ilpwm_pkg.sv
package ilpwm_pkg;

    localparam int unsigned DEF_PERIOD = 1000;
    localparam int unsigned DEF_NUM_PH = 3;
    localparam int unsigned DEF_DUTY_W = 10;

    // Rounded start offset of phase idx within a period split nph ways
    function automatic int unsigned ph_offset(input int unsigned idx,
                                              input int unsigned period,
                                              input int unsigned nph);
        return (idx * period + nph / 2) / nph;
    endfunction

    function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

    // Control bundle handed from the timebase to the rest of the block
    typedef struct packed {
        logic run;    // enabled and out of reset
        logic start;  // count is zero this cycle
        logic wrap;   // last count of the period this cycle
    } tb_ctl_t;

endpackage

// File: rtl/ilpwm_timebase.sv
module ilpwm_timebase
    import ilpwm_pkg::*;
#(
    parameter int unsigned PERIOD = DEF_PERIOD,
    parameter int unsigned CNT_W  = $clog2(PERIOD)
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             run_i,
    output logic [CNT_W-1:0] cnt_o,
    output tb_ctl_t          ctl_o
);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(PERIOD - 1);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk_i) begin
        if (rst_i || !run_i) begin
            cnt_q <= '0;
        end else if (cnt_q == LAST) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + CNT_W'(1);
        end
    end

    always_comb begin
        ctl_o.run   = run_i;
        ctl_o.start = run_i && (cnt_q == '0);
        ctl_o.wrap  = run_i && (cnt_q == LAST);
    end

    assign cnt_o = cnt_q;

    // R1
    cnt_bound_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        cnt_q < CNT_W'(PERIOD));
    // R1
    cnt_wrap_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (run_i && cnt_q == LAST) |=> (cnt_q == '0));
    // R8
    cnt_clear_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        !run_i |=> (cnt_q == '0));
endmodule

// File: rtl/ilpwm_duty_hold.sv
module ilpwm_duty_hold
    import ilpwm_pkg::*;
#(
    parameter int unsigned PERIOD = DEF_PERIOD,
    parameter int unsigned DUTY_W = DEF_DUTY_W,
    parameter int unsigned CMP_W  = 11
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  tb_ctl_t           ctl_i,
    input  logic [DUTY_W-1:0] duty_i,
    input  logic              vld_i,
    output logic [CMP_W-1:0]  act_o
);
    localparam logic [CMP_W-1:0] FULL = CMP_W'(PERIOD);

    logic [CMP_W-1:0] pend_q, act_q, sat, pend_nxt;
    logic             load;

    always_comb begin
        sat      = (CMP_W'(duty_i) > FULL) ? FULL : CMP_W'(duty_i);
        pend_nxt = vld_i ? sat : pend_q;
        // idle or the last count: the next cycle begins a fresh period
        load     = !ctl_i.run || ctl_i.wrap;
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            pend_q <= '0;
            act_q  <= '0;
        end else begin
            pend_q <= pend_nxt;
            if (load) begin
                act_q <= pend_nxt;
            end
        end
    end

    assign act_o = act_q;

    // R5
    act_cap_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        act_q <= FULL);
    // R6
    act_hold_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (ctl_i.run && !ctl_i.wrap) |=> $stable(act_q));
endmodule

// File: rtl/ilpwm_phase.sv
module ilpwm_phase
    import ilpwm_pkg::*;
#(
    parameter int unsigned PERIOD = DEF_PERIOD,
    parameter int unsigned CNT_W  = 10,
    parameter int unsigned CMP_W  = 11,
    parameter int unsigned OFFSET = 0
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             run_i,
    input  logic [CNT_W-1:0] cnt_i,
    input  logic [CMP_W-1:0] duty_i,
    output logic             gate_o
);
    logic [CNT_W-1:0] rel;

    // position inside this phase's own window, wrapped modulo the period
    always_comb begin
        if (cnt_i >= CNT_W'(OFFSET)) begin
            rel = cnt_i - CNT_W'(OFFSET);
        end else begin
            rel = cnt_i + CNT_W'(PERIOD - OFFSET);
        end
        gate_o = run_i && (CMP_W'(rel) < duty_i);
    end

    // R4
    zero_low_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (duty_i == '0) |-> !gate_o);
    // R5
    full_on_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (run_i && duty_i == CMP_W'(PERIOD)) |-> gate_o);
    // R8
    idle_low_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        !run_i |-> !gate_o);
endmodule

// File: rtl/ilpwm_interleave.sv
module ilpwm_interleave
    import ilpwm_pkg::*;
#(
    parameter int unsigned PERIOD = DEF_PERIOD,
    parameter int unsigned NUM_PH = DEF_NUM_PH,
    parameter int unsigned DUTY_W = DEF_DUTY_W
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              en_i,
    input  logic [DUTY_W-1:0] duty_i,
    input  logic              duty_vld_i,
    output logic [NUM_PH-1:0] gate_o,
    output logic              period_start_o
);
    localparam int unsigned CNT_W = $clog2(PERIOD);
    localparam int unsigned CMP_W = max_u(CNT_W, max_u(DUTY_W, $clog2(PERIOD + 1))) + 1;

    logic             run;
    logic [CNT_W-1:0] cnt;
    logic [CMP_W-1:0] act;
    tb_ctl_t          ctl;

    assign run = en_i && !rst_i;

    ilpwm_timebase #(.PERIOD(PERIOD), .CNT_W(CNT_W)) u_tb (
        .clk_i (clk_i),
        .rst_i (rst_i),
        .run_i (run),
        .cnt_o (cnt),
        .ctl_o (ctl)
    );

    ilpwm_duty_hold #(.PERIOD(PERIOD), .DUTY_W(DUTY_W), .CMP_W(CMP_W)) u_duty (
        .clk_i  (clk_i),
        .rst_i  (rst_i),
        .ctl_i  (ctl),
        .duty_i (duty_i),
        .vld_i  (duty_vld_i),
        .act_o  (act)
    );

    for (genvar k = 0; k < NUM_PH; k++) begin : g_ph
        ilpwm_phase #(
            .PERIOD (PERIOD),
            .CNT_W  (CNT_W),
            .CMP_W  (CMP_W),
            .OFFSET (ph_offset(k, PERIOD, NUM_PH))
        ) u_ph (
            .clk_i  (clk_i),
            .rst_i  (rst_i),
            .run_i  (ctl.run),
            .cnt_i  (cnt),
            .duty_i (act),
            .gate_o (gate_o[k])
        );
    end

    assign period_start_o = ctl.start;

    // R2
    start_single_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        period_start_o |=> !period_start_o);
    // R8
    start_idle_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        !en_i |-> !period_start_o);
endmodule

// File: tb/test_ilpwm_interleave.sv
module test_ilpwm_interleave;
    localparam int P = 1000;

    logic       clk = 1'b0;
    logic       rst_i = 1'b1;
    logic       en_i = 1'b0;
    logic [9:0] duty_i = '0;
    logic       duty_vld_i = 1'b0;
    logic [2:0] gate_o;
    logic       period_start_o;

    int checks = 0;
    int errors = 0;
    string tag = "R3";

    // independent reference state
    int m_cnt = 0, m_pend = 0, m_act = 0;
    int off[3] = '{0, 333, 667};
    int run_len = -1, per_duty = 0;
    int hi[3] = '{0, 0, 0};
    int since = 0;
    bit since_ok = 0;

    always #4 clk = ~clk;

    ilpwm_interleave i_ilpwm_interleave (
        .clk_i(clk), .rst_i(rst_i), .en_i(en_i), .duty_i(duty_i),
        .duty_vld_i(duty_vld_i), .gate_o(gate_o), .period_start_o(period_start_o)
    );

    function automatic int sat(input int d);
        return (d > P) ? P : d;
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d (count %0d)", req, act, exp, m_cnt);
        end
    endtask

    // one cycle: drive, compare after settle, then advance the reference at the edge
    task automatic tick(input bit e, input bit v, input int d);
        bit live;
        en_i = e; duty_vld_i = v; duty_i = 10'(d);
        #1;
        live = e && !rst_i;
        chk((tag == "R3") ? "R2" : tag, int'(period_start_o), int'(live && m_cnt == 0));
        for (int k = 0; k < 3; k++) begin
            chk(tag, int'(gate_o[k]), int'(live && (((m_cnt + P - off[k]) % P) < m_act)));
        end
        if (live && m_cnt == 0 && m_act > 333) chk("R10", int'(gate_o[2]), 1);
        if (live) begin
            if (period_start_o) begin
                if (since_ok) chk("R1", since, P);
                since = 0; since_ok = 1;
            end
            since++;
            if (m_cnt == 0) begin
                if (run_len == P) for (int k = 0; k < 3; k++) chk("R9", hi[k], per_duty);
                run_len = 0; per_duty = m_act;
                for (int k = 0; k < 3; k++) hi[k] = 0;
            end
            if (run_len >= 0) begin
                run_len++;
                for (int k = 0; k < 3; k++) hi[k] += int'(gate_o[k]);
            end
        end else begin
            run_len = -1; since_ok = 0;
        end
        @(posedge clk);
        if (rst_i) begin
            m_cnt = 0; m_pend = 0; m_act = 0;
        end else begin
            int pn;
            pn = v ? sat(d) : m_pend;
            if (!e) begin
                m_cnt = 0; m_act = pn;
            end else if (m_cnt == P - 1) begin
                m_cnt = 0; m_act = pn;
            end else begin
                m_cnt++;
            end
            m_pend = pn;
        end
        @(negedge clk);
    endtask

    task automatic run_duty(input int d, input int periods);
        tick(1, 1, d);
        while (m_cnt != 0) tick(1, 0, d);
        for (int i = 0; i < periods * P + 1; i++) tick(1, 0, d);
    endtask

    initial begin
        #(200000 * 8);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'h1f2e3d));
        @(negedge clk);
        tag = "R8";
        for (int i = 0; i < 4; i++) tick(1, 1, 500);
        rst_i = 1'b0;

        tag = "R4"; run_duty(0, 1);
        tag = "R3";
        run_duty(1, 1);
        run_duty(332, 1);
        run_duty(333, 1);
        run_duty(334, 1);
        run_duty(999, 1);
        tag = "R5";
        run_duty(1000, 1);
        run_duty(1023, 1);

        // R6: strobe mid-period, old value holds until count 0
        tag = "R6";
        run_duty(100, 1);
        while (m_cnt != 500) tick(1, 0, 0);
        tick(1, 1, 800);
        while (m_cnt != 700) tick(1, 0, 0);
        #1 chk("R6", int'(gate_o[0]), 0);
        tick(1, 0, 0);
        while (m_cnt != 700) tick(1, 0, 0);
        #1 chk("R6", int'(gate_o[0]), 1);
        tick(1, 0, 0);

        // R7: duty wiggles with no strobe
        tag = "R7";
        for (int i = 0; i < 2 * P; i++) tick(1, 0, int'($urandom % 1024));

        // R8: drop enable mid-period, strobe while idle, re-enable
        tag = "R8";
        while (m_cnt != 400) tick(1, 0, 0);
        tick(0, 0, 0);
        tick(0, 1, 600);
        for (int i = 0; i < 3; i++) tick(0, 0, 0);
        #1 chk("R8", int'(gate_o), 0);
        tick(1, 0, 0);
        for (int i = 0; i < P + 5; i++) tick(1, 0, 0);

        // random mix: random duty and strobe position, occasional idle gaps
        tag = "R3";
        for (int p = 0; p < 16; p++) begin
            int d, pos;
            d = int'($urandom % 1024);
            pos = int'($urandom % P);
            for (int c = 0; c < P; c++) begin
                tick(1, c == pos, (c == pos) ? d : int'($urandom % 1024));
            end
            if ($urandom % 5 == 0) begin
                tag = "R8";
                for (int i = 0; i < 3; i++) tick(0, 0, 0);
                tag = "R3";
            end
        end
        tick(1, 1, 700);
        while (m_cnt != P - 1) tick(1, 0, 0);
        tick(1, 1, 250);
        for (int i = 0; i < P + 2; i++) tick(1, 0, 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule